// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (one clock line, one open-drain data line) that sits in front of a byte-wide storage array of 2^ADDR_W bytes. With the default ADDR_W of 13 that is 8192 bytes, or 64 Kbit. The two bus lines are sampled by the system clock through a synchronizer, and START and STOP conditions are recognised from their edges. Every transaction has the same layout: a START, a command byte, two address bytes with the high byte first, and then data bytes. The data flows from master to slave when the command asks for a write, and from slave to master when it asks for a read. The side that receives each 8-bit unit answers it in a ninth acknowledge clock.

Written bytes are held in a staging buffer. They reach the array only when a STOP closes the transaction. That STOP starts a modelled nonvolatile write cycle of WR_CYCLES system clocks, and the `busy` flag is high for its whole length. While the cycle runs, the slave refuses every command byte with a NACK, so a master can poll for completion. The block has no streaming interface: the bus pins and `busy` are plain signals. The open-drain line is modelled as `sda_oe`, which pulls the line low when high, and `sda_i`, which returns the resolved line level. The system clock must run at least 8 times faster than SCL.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `busy` is 0, and the slave waits for a START.
- R2: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP. A START at any point, including in the middle of a byte, restarts framing at the command byte.
- R3: The command byte carries the device code in bits 7..1 (DEV_CODE, default 7'h50) and the direction in bit 0 (1 means read, 0 means write). A matching code is acknowledged by holding SDA low during the ninth clock. A code that does not match is answered with a NACK, and the slave then ignores the bus until the next START.
- R4: Two address bytes follow the command, high byte first, and each one is acknowledged. Only the low ADDR_W bits of the 16 received bits are kept.
- R5: On a write, each data byte is acknowledged and staged. The staged bytes go to consecutive addresses that start at the received address and wrap modulo 2^ADDR_W. They reach the array only when a STOP ends the transaction.
- R6: A repeated START that interrupts a write discards the staged bytes. A STOP that arrives before any data byte has been staged also writes nothing. In both cases `busy` stays 0.
- R7: A committing STOP raises `busy` for exactly WR_CYCLES system clocks. All staged bytes are in the array by the time `busy` falls.
- R8: While `busy` is 1, every command byte is answered with a NACK, whether its code matches and whatever its direction bit. This lets the master use acknowledge polling.
- R9: On a read, the slave sends bytes MSB first, starting at the received address. The address increments after each byte and wraps modulo 2^ADDR_W. The slave keeps sending while the master acknowledges. A master NACK makes the slave release SDA and return to idle.
- R10: A write data byte beyond BUF_DEPTH (default 32) staged bytes gets a NACK and is dropped. The bytes already staged are still committed at STOP.
- R11: The slave changes its drive on SDA only while SCL is low. It samples SDA on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| busy | output | 1 | High while the modelled nonvolatile write cycle runs |

## Verification
A wrong framing state shows up within one byte as a missing or misplaced acknowledge: a correct ninth clock is held low, and a wrong one stays high. A wrong address pointer or a wrong staging index does not show up when the write is issued. It appears only after the write cycle ends, when the bytes read back differ from the bench's own model. A wrong cycle counter shows directly as a `busy` pulse that is not exactly WR_CYCLES clocks long, or as a polling command that is acknowledged while `busy` is still high. A monitor counts any rise of `sda_oe` while SCL is high, which catches drive timing errors on the first acknowledge.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    FLD_CMD,
    FLD_AHI,
    FLD_ALO,
    FLD_DATA
  } field_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_p     <= scl_chain[STAGES-1];
      sda_p     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s    = scl_chain[STAGES-1];
  assign sda_s    = sda_chain[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // Data edges while the clock stays high mark the frame boundaries.
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_mem_store.sv
module tw_mem_store #(
  parameter int ADDR_W    = 13,
  parameter int BUF_DEPTH = 32,
  parameter int WR_CYCLES = 2000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 push,
  input  logic [$clog2(BUF_DEPTH)-1:0]         push_idx,
  input  logic [7:0]                           push_data,
  input  logic                                 commit_go,
  input  logic [ADDR_W-1:0]                    commit_base,
  input  logic [$clog2(BUF_DEPTH+1)-1:0]       commit_cnt,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic [7:0]                           rd_data,
  output logic                                 busy
);
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int WC_W      = $clog2(WR_CYCLES + 1);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam logic [WC_W-1:0] CYC_LOAD = WC_W'(WR_CYCLES);

  logic [7:0]        stage_q [BUF_DEPTH];
  logic [7:0]        array_q [MEM_DEPTH];
  logic [WC_W-1:0]   cyc_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  left_q, ci_q;

  // Write-cycle sequencer: one staged byte per clock while the cycle runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      base_q <= '0;
      left_q <= '0;
      ci_q   <= '0;
    end else begin
      if (commit_go && cyc_q == '0) begin
        cyc_q  <= CYC_LOAD;
        base_q <= commit_base;
        left_q <= commit_cnt;
        ci_q   <= '0;
      end else begin
        if (cyc_q != '0) cyc_q <= cyc_q - 1'b1;
        if (left_q != '0) begin
          left_q <= left_q - 1'b1;
          ci_q   <= ci_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) stage_q[push_idx] <= push_data;
    if (left_q != '0) array_q[base_q + ADDR_W'(ci_q)] <= stage_q[ci_q[IDX_W-1:0]];
    rd_data <= array_q[rd_addr];
  end

  assign busy = (cyc_q != '0);

  assert_commit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy);
  assert_push_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !busy);
  assert_drain_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (left_q == '0));
endmodule

// File: rtl/tw_proto.sv
module tw_proto
  import tw_mem_pkg::*;
#(
  parameter logic [6:0] DEV_CODE  = 7'h50,
  parameter int         ADDR_W    = 13,
  parameter int         BUF_DEPTH = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            scl_s,
  input  logic                            sda_s,
  input  logic                            scl_rise,
  input  logic                            scl_fall,
  input  logic                            start_ev,
  input  logic                            stop_ev,
  input  logic                            busy,
  input  logic [7:0]                      rd_data,
  output logic                            sda_oe,
  output logic                            push,
  output logic [$clog2(BUF_DEPTH)-1:0]    push_idx,
  output logic [7:0]                      push_data,
  output logic                            commit_go,
  output logic [ADDR_W-1:0]               commit_base,
  output logic [$clog2(BUF_DEPTH+1)-1:0]  commit_cnt,
  output logic [ADDR_W-1:0]               rd_addr
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BUF_DEPTH);

  phase_t            phase;
  field_t            field;
  logic [2:0]        bcnt;
  logic [7:0]        sh;
  logic              ack_q, ack_on, is_read, wr_armed;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  wcnt;
  logic [7:0]        nb;
  logic              ack_now;

  assign nb = {sh[6:0], sda_s};

  always_comb begin
    unique case (field)
      FLD_CMD:  ack_now = (nb[7:1] == DEV_CODE) && !busy;
      FLD_DATA: ack_now = (wcnt < DEPTH_C);
      default:  ack_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      field       <= FLD_CMD;
      bcnt        <= '0;
      sh          <= '0;
      ack_q       <= 1'b0;
      ack_on      <= 1'b0;
      is_read     <= 1'b0;
      wr_armed    <= 1'b0;
      ptr         <= '0;
      wcnt        <= '0;
      sda_oe      <= 1'b0;
      push        <= 1'b0;
      push_idx    <= '0;
      push_data   <= '0;
      commit_go   <= 1'b0;
      commit_base <= '0;
      commit_cnt  <= '0;
    end else begin
      push      <= 1'b0;
      commit_go <= 1'b0;
      if (start_ev) begin
        phase    <= PH_RX;
        field    <= FLD_CMD;
        bcnt     <= '0;
        sda_oe   <= 1'b0;
        wr_armed <= 1'b0;
        wcnt     <= '0;
        ack_on   <= 1'b0;
      end else if (stop_ev) begin
        phase    <= PH_IDLE;
        sda_oe   <= 1'b0;
        wr_armed <= 1'b0;
        if (wr_armed && wcnt != '0) begin
          commit_go   <= 1'b1;
          commit_base <= ptr;
          commit_cnt  <= wcnt;
        end
      end else begin
        unique case (phase)
          PH_RX: if (scl_rise) begin
            sh <= nb;
            if (bcnt == 3'd7) begin
              bcnt   <= '0;
              ack_q  <= ack_now;
              ack_on <= 1'b0;
              phase  <= PH_RXACK;
              unique case (field)
                FLD_CMD: begin
                  is_read <= nb[0];
                  field   <= FLD_AHI;
                end
                FLD_AHI: begin
                  ptr   <= ADDR_W'({nb, ptr[7:0]});
                  field <= FLD_ALO;
                end
                FLD_ALO: begin
                  ptr      <= {ptr[ADDR_W-1:8], nb};
                  field    <= FLD_DATA;
                  wr_armed <= !is_read;
                end
                default: if (ack_now) begin
                  push      <= 1'b1;
                  push_idx  <= wcnt[IDX_W-1:0];
                  push_data <= nb;
                  wcnt      <= wcnt + 1'b1;
                end
              endcase
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          PH_RXACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= ack_q;
            end else begin
              ack_on <= 1'b0;
              if (!ack_q) begin
                sda_oe <= 1'b0;
                phase  <= PH_IDLE;
              end else if (field == FLD_DATA && is_read) begin
                sda_oe <= ~rd_data[7];
                sh     <= {rd_data[6:0], 1'b0};
                bcnt   <= '0;
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: if (scl_fall) begin
            if (bcnt == 3'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_TXACK;
              ptr    <= ptr + 1'b1;
              ack_on <= 1'b0;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
              bcnt   <= bcnt + 1'b1;
            end
          end
          PH_TXACK: begin
            if (scl_rise) begin
              if (sda_s) phase <= PH_IDLE;
              else       ack_on <= 1'b1;
            end else if (scl_fall && ack_on) begin
              ack_on <= 1'b0;
              sda_oe <= ~rd_data[7];
              sh     <= {rd_data[6:0], 1'b0};
              bcnt   <= '0;
              phase  <= PH_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = ptr;

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_cmd_ack_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && phase == PH_RXACK && field == FLD_AHI) |-> !busy);
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase == PH_IDLE)) |-> !sda_oe);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> (commit_cnt <= DEPTH_C));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter logic [6:0] DEV_CODE    = 7'h50,
  parameter int         ADDR_W      = 13,
  parameter int         BUF_DEPTH   = 32,
  parameter int         WR_CYCLES   = 2000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic push, commit_go;
  logic [IDX_W-1:0]  push_idx;
  logic [7:0]        push_data, rd_data;
  logic [ADDR_W-1:0] commit_base, rd_addr;
  logic [CNT_W-1:0]  commit_cnt;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tw_proto #(.DEV_CODE(DEV_CODE), .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe),
    .push(push), .push_idx(push_idx), .push_data(push_data),
    .commit_go(commit_go), .commit_base(commit_base), .commit_cnt(commit_cnt),
    .rd_addr(rd_addr)
  );

  tw_mem_store #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_idx(push_idx), .push_data(push_data),
    .commit_go(commit_go), .commit_base(commit_base), .commit_cnt(commit_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: tb/test_twowire_mem_slave.sv
module test_twowire_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;
  localparam int WR_CYC     = 2000;
  localparam int DEPTH      = 32;
  localparam logic [7:0] CMD_W = 8'hA0;
  localparam logic [7:0] CMD_R = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy, sda_line;
  int n_chk = 0;
  int n_bad = 0;
  int oe_rise_hi = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [8192];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twowire_mem_slave i_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl) oe_rise_hi <= oe_rise_hi + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic b_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic b_put(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); acked = !sda_line; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic b_get(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_line; w(Q); scl = 1'b0; w(Q);
    end
    sda_m = !mack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  // START, command, address; returns the number of NACKed bytes among the three.
  task automatic hdr(input logic [7:0] cmd, input logic [15:0] a, output int nacks);
    logic ak;
    nacks = 0;
    b_start;
    b_put(cmd, ak); if (!ak) nacks++;
    b_put(a[15:8], ak); if (!ak) nacks++;
    b_put(a[7:0], ak); if (!ak) nacks++;
  endtask

  task automatic wr_bytes(input logic [15:0] a, input int n, input logic [7:0] seed,
                          input string req);
    int nk;
    logic ak;
    hdr(CMD_W, a, nk);
    chk({req, " header acks"}, nk, 0);
    for (int i = 0; i < n; i++) begin
      b_put(pat(seed, i), ak);
      chk({req, " data ack"}, int'(ak), (i < DEPTH) ? 1 : 0);
      if (i < DEPTH) model[13'(a + 16'(i))] = pat(seed, i);
    end
  endtask

  // STOP, then count the clocks on which busy is high.
  task automatic stop_measure(output int cyc);
    int guard = 0;
    logic seen = 1'b0;
    cyc = 0;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1;
    while (guard < 10000) begin
      @(negedge clk);
      guard++;
      if (busy) begin seen = 1'b1; cyc++; end
      else if (seen) break;
    end
    w(Q);
  endtask

  task automatic rd_check(input logic [15:0] a, input int n, input string req);
    int nk;
    logic [7:0] b;
    hdr(CMD_R, a, nk);
    chk({req, " read header acks"}, nk, 0);
    for (int i = 0; i < n; i++) begin
      b_get(i != n - 1, b);
      chk({req, " read data"}, int'(b), int'(model[13'(a + 16'(i))]));
    end
    w(Q);
    chk("R9 released after master NACK", int'(sda_oe), 0);
    b_stop;
  endtask

  task automatic t_reset;
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_basic;
    int cyc;
    wr_bytes(16'h0123, 3, 8'hA5, "R5");
    stop_measure(cyc);
    chk("R7 busy length", cyc, WR_CYC);
    rd_check(16'h0123, 3, "R9 R5");
  endtask

  task automatic t_poll;
    int nk;
    logic ak;
    wr_bytes(16'h0200, 1, 8'h3C, "R5");
    b_stop;
    b_start; b_put(CMD_W, ak); chk("R8 write cmd NACK while busy", int'(ak), 0); b_stop;
    b_start; b_put(CMD_R, ak); chk("R8 read cmd NACK while busy", int'(ak), 0); b_stop;
    while (busy) @(negedge clk);
    b_start; b_put(CMD_W, ak); chk("R8 cmd ACK after busy", int'(ak), 1); b_stop;
    w(4*Q);
    chk("R6 STOP without data leaves busy low", int'(busy), 0);
    hdr(CMD_W, 16'h0201, nk); b_stop;
    w(4*Q);
    chk("R6 STOP after address only leaves busy low", int'(busy), 0);
    rd_check(16'h0200, 1, "R8");
  endtask

  task automatic t_wrong_code;
    logic ak;
    b_start; b_put(8'hA2, ak); chk("R3 mismatched code NACK", int'(ak), 0);
    b_put(CMD_W, ak); chk("R3 bus ignored until START", int'(ak), 0);
    b_stop; w(4*Q);
    chk("R3 no write after mismatch", int'(busy), 0);
  endtask

  task automatic t_abort;
    int nk;
    logic ak;
    hdr(CMD_W, 16'h0123, nk);
    b_put(8'h11, ak); b_put(8'h22, ak);
    // Repeated START mid-byte: four bits, then START again (R2).
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    b_start; b_put(CMD_R, ak);
    chk("R2 START mid-byte restarts framing", int'(ak), 1);
    b_stop; w(4*Q);
    chk("R6 repeated START discards write", int'(busy), 0);
    rd_check(16'h0123, 3, "R6");
  endtask

  task automatic t_wrap;
    int cyc;
    wr_bytes(16'hFFFF, 2, 8'h77, "R4 R5");
    stop_measure(cyc);
    rd_check(16'h1FFF, 2, "R4 R5 wrap");
    rd_check(16'hE000, 1, "R4 high bits ignored");
  endtask

  task automatic t_overflow;
    int cyc;
    wr_bytes(16'h0420, 1, 8'h5A, "R10 pre");
    stop_measure(cyc);
    wr_bytes(16'h0400, DEPTH + 1, 8'h01, "R10");
    stop_measure(cyc);
    chk("R10 busy after overflow write", cyc, WR_CYC);
    rd_check(16'h041E, 3, "R10");
  endtask

  initial begin
    w(10); rst_n = 1'b1; w(10);
    t_reset;
    t_basic;
    t_poll;
    t_wrong_code;
    t_abort;
    t_wrap;
    t_overflow;
    chk("R11 sda_oe rises while SCL high", oe_rise_hi, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule